// File: doc/BRIEF.md
# Asynchronous External Memory Bus Controller

This block turns single requests from an internal port into accesses on an external asynchronous memory bus. A request carries a halfword address, write data, two byte enables and a read/write flag, and is taken with a valid/ready handshake. The top three address bits pick one of eight active-low chip selects. Each select has its own 8-bit configuration word that sets its bus width, its wait-state count, its read-strobe protocol and its data-float turnaround.

The controller runs on an internal clock at twice the bus rate. A phase bit toggles every internal cycle and is driven out as the bus clock, so one internal cycle is one bus half-period and every bus edge is an ordinary register update. An access drives chip select, address and byte-lane strobes on a falling bus edge. It then pulses the read or write strobe, which an external wait input can stretch, and releases the select one half-period after the strobe has gone high. Reads return the captured word with a one-cycle response pulse. After a read, the controller holds off new requests until the float interval of that select has run out.

Top module: `ebc_top`

## Requirements
- R1: Request bits [25:23] select a chip select. During an access exactly that `extNcs` bit is low. All bits are high at reset and between accesses, and a strobe is never low while all selects are high.
- R2: `extAddr` carries request bits [22:0] from the chip-select fall to its rise. Configuration bit 0 set means a 16-bit select: `extNlbA0` = not be[0] and `extNub` = not be[1]. Configuration bit 0 clear means an 8-bit select: `extNub` stays high, `extNlbA0` = not be[0] (the A0 line), and the write byte (the low byte if be[0] is set, otherwise the high byte) is driven on both data lanes.
- R3: With configuration bits [3:1] (wait count n) equal to zero, `extNwr` falls one cycle after the chip select, together with a rising bus clock, and stays low for one cycle, ending on a falling bus clock.
- R4: With n > 0, `extNwr` stays low for 2n cycles. It rises together with a rising bus clock.
- R5: With configuration bit 4 clear (standard read), `extNrd` falls one cycle after the chip select on a rising bus clock, stays low for 2n+1 cycles and rises on a falling bus clock.
- R6: With configuration bit 4 set (early read), `extNrd` falls in the same cycle as the chip select on a falling bus clock, and stays low for 2n+2 cycles.
- R7: `extNwait` is sampled at each rising bus edge that comes after a strobe has fallen, up to and including the edge that would release it. Each low sample lengthens the strobe by two cycles. A zero-wait write contains no such edge.
- R8: Read and write strobes are never low together. Write data stays driven, and chip select and address stay unchanged, in the cycle after `extNwr` rises.
- R9: The bus word present in the cycle in which `extNrd` rises is returned on `rspRdata`, with `rspValid` high for exactly that one cycle. In 8-bit mode the low data byte is copied into both halves. Writes produce no response.
- R10: After a read, the data bus is not driven. The next chip-select fall comes exactly 2F+1 cycles after the read's chip-select rise, where F is configuration bits [7:5] plus one when n is zero.
- R11: `reqReady` is low in reset. It is high only when no access is in progress, the float interval is over and the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rstN | input | 1 | Active-low reset |
| cfgTable | input | 64 | Eight configuration bytes, select k in bits [8k+7:8k] |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken on this edge when valid |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | 26 | Halfword address, bits [25:23] select |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 0 low byte |
| rspValid | output | 1 | One-cycle read response |
| rspRdata | output | 16 | Read data |
| extMck | output | 1 | Bus clock |
| extNcs | output | 8 | Active-low chip selects |
| extAddr | output | 23 | Halfword address lines |
| extNlbA0 | output | 1 | Lower byte strobe, or A0 in 8-bit mode |
| extNub | output | 1 | Upper byte strobe |
| extNrd | output | 1 | Active-low read strobe |
| extNwr | output | 1 | Active-low write strobe |
| extDataOut | output | 16 | Data driven onto the bus |
| extDataOe | output | 1 | Drive enable for extDataOut |
| extDataIn | input | 16 | Data read from the bus |
| extNwait | input | 1 | Active-low wait request |

## Verification
Two events can meet on one edge. The first case is a low wait sample on the rising edge that would otherwise end an n-wait write. The bench provokes it by holding `extNwait` low for several cycles from the start of the strobe. It checks that the measured width equals the base width plus two cycles for every low sample the bench counts itself. The second case is the float expiry and a waiting request. The bench issues the next request back to back behind a read, so the request is already pending when the float count runs out, and it checks the exact distance between the two chip-select edges.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int WAIT_W = 3;
  localparam int FLT_W  = 3;
  localparam int CFG_W  = FLT_W + 1 + WAIT_W + 1;
  localparam int HALF_W = WAIT_W + 2;   // edges until strobe release
  localparam int FCNT_W = FLT_W + 2;    // float count in half-periods

  typedef struct packed {
    logic [FLT_W-1:0]  flt;
    logic              early;
    logic [WAIT_W-1:0] waits;
    logic              wide;
  } csCfg_t;

  typedef struct packed {
    logic latch;    // take request, drive select/address/data
    logic finish;   // release select and data drive
    logic capture;  // sample read data
  } dpCtrl_t;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} busState_t;
endpackage

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [WAIT_W-1:0] selWaits,
  input  logic              selEarly,
  input  logic [FLT_W-1:0]  selFlt,
  input  logic              extNwait,
  output logic              reqReady,
  output logic              extMck,
  output logic              extNrd,
  output logic              extNwr,
  output dpCtrl_t           dpCtl
);
  busState_t         state;
  logic              phase;
  logic [HALF_W-1:0] halfLeft;
  logic              isRead;
  logic [WAIT_W-1:0] waitsR;
  logic [FLT_W-1:0]  fltR;
  logic [FCNT_W-1:0] floatCnt;

  logic              accept, stallNow, releaseNow;
  logic [HALF_W-1:0] wrHalves, rdHalves, earlyHalves;
  logic [FCNT_W-1:0] floatLoad;

  // phase==0 means the coming edge raises the bus clock
  assign stallNow   = !phase && !extNwait;
  assign reqReady   = (state == S_IDLE) && (floatCnt == '0) && phase;
  assign accept     = reqValid && reqReady;
  assign releaseNow = (state == S_STROBE) && !stallNow && (halfLeft == HALF_W'(1));
  assign extMck     = phase;

  assign wrHalves    = (waitsR == '0) ? HALF_W'(1) : HALF_W'({waitsR, 1'b0});
  assign rdHalves    = HALF_W'({waitsR, 1'b0}) + HALF_W'(1);
  assign earlyHalves = HALF_W'({selWaits, 1'b0}) + HALF_W'(2);
  assign floatLoad   = (FCNT_W'(fltR) + FCNT_W'(waitsR == '0)) << 1;

  assign dpCtl.latch   = accept;
  assign dpCtl.finish  = (state == S_HOLD);
  assign dpCtl.capture = releaseNow && isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phase    <= 1'b0;
      halfLeft <= '0;
      isRead   <= 1'b0;
      waitsR   <= '0;
      fltR     <= '0;
      floatCnt <= '0;
      extNrd   <= 1'b1;
      extNwr   <= 1'b1;
    end else begin
      phase <= ~phase;
      if (floatCnt != '0) floatCnt <= floatCnt - FCNT_W'(1);
      unique case (state)
        S_IDLE: if (accept) begin
          isRead <= !reqWrite;
          waitsR <= selWaits;
          fltR   <= selFlt;
          if (!reqWrite && selEarly) begin
            extNrd   <= 1'b0;
            halfLeft <= earlyHalves;
            state    <= S_STROBE;
          end else begin
            state <= S_SETUP;
          end
        end
        S_SETUP: begin
          state <= S_STROBE;
          if (isRead) begin
            extNrd   <= 1'b0;
            halfLeft <= rdHalves;
          end else begin
            extNwr   <= 1'b0;
            halfLeft <= wrHalves;
          end
        end
        S_STROBE: begin
          if (stallNow) halfLeft <= halfLeft + HALF_W'(1);
          else if (releaseNow) begin
            extNrd <= 1'b1;
            extNwr <= 1'b1;
            state  <= S_HOLD;
          end else halfLeft <= halfLeft - HALF_W'(1);
        end
        S_HOLD: begin
          state    <= S_IDLE;
          floatCnt <= isRead ? floatLoad : '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = 3,
  parameter int EXT_AW = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtl,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [EXT_AW-1:0] reqOff,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  input  logic              reqWrite,
  input  logic              selWide,
  input  logic [DATA_W-1:0] extDataIn,
  output logic [NUM_CS-1:0] extNcs,
  output logic [EXT_AW-1:0] extAddr,
  output logic              extNlbA0,
  output logic              extNub,
  output logic [DATA_W-1:0] extDataOut,
  output logic              extDataOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);
  localparam int LANE_W = DATA_W / 2;

  logic [NUM_CS-1:0] csOnehot;
  logic [LANE_W-1:0] wrByte;
  logic              wideR;

  always_comb begin
    for (int k = 0; k < NUM_CS; k++) csOnehot[k] = (reqSel == SEL_W'(k));
  end

  assign wrByte = reqBe[0] ? reqWdata[LANE_W-1:0] : reqWdata[DATA_W-1:LANE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extNcs     <= '1;
      extAddr    <= '0;
      extNlbA0   <= 1'b1;
      extNub     <= 1'b1;
      extDataOut <= '0;
      extDataOe  <= 1'b0;
      wideR      <= 1'b0;
      rspValid   <= 1'b0;
      rspRdata   <= '0;
    end else begin
      rspValid <= dpCtl.capture;
      if (dpCtl.capture)
        rspRdata <= wideR ? extDataIn : {2{extDataIn[LANE_W-1:0]}};
      if (dpCtl.latch) begin
        extNcs     <= ~csOnehot;
        extAddr    <= reqOff;
        wideR      <= selWide;
        extNlbA0   <= ~reqBe[0];
        extNub     <= selWide ? ~reqBe[1] : 1'b1;
        extDataOut <= selWide ? reqWdata : {2{wrByte}};
        extDataOe  <= reqWrite;
      end else if (dpCtl.finish) begin
        extNcs    <= '1;
        extDataOe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ebc_top.sv
module ebc_top
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CS*CFG_W-1:0] cfgTable,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [1:0]              reqBe,
  output logic                    rspValid,
  output logic [DATA_W-1:0]       rspRdata,
  output logic                    extMck,
  output logic [NUM_CS-1:0]       extNcs,
  output logic [ADDR_W-$clog2(NUM_CS)-1:0] extAddr,
  output logic                    extNlbA0,
  output logic                    extNub,
  output logic                    extNrd,
  output logic                    extNwr,
  output logic [DATA_W-1:0]       extDataOut,
  output logic                    extDataOe,
  input  logic [DATA_W-1:0]       extDataIn,
  input  logic                    extNwait
);
  localparam int SEL_W  = $clog2(NUM_CS);
  localparam int EXT_AW = ADDR_W - SEL_W;

  logic [SEL_W-1:0] sel;
  csCfg_t           selCfg;
  dpCtrl_t          dpCtl;

  assign sel    = reqAddr[ADDR_W-1 -: SEL_W];
  assign selCfg = csCfg_t'(cfgTable[sel*CFG_W +: CFG_W]);

  ebc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .selWaits(selCfg.waits), .selEarly(selCfg.early), .selFlt(selCfg.flt),
    .extNwait(extNwait), .reqReady(reqReady), .extMck(extMck),
    .extNrd(extNrd), .extNwr(extNwr), .dpCtl(dpCtl)
  );

  ebc_datapath #(.NUM_CS(NUM_CS), .SEL_W(SEL_W), .EXT_AW(EXT_AW), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .reqSel(sel),
    .reqOff(reqAddr[EXT_AW-1:0]), .reqWdata(reqWdata), .reqBe(reqBe),
    .reqWrite(reqWrite), .selWide(selCfg.wide), .extDataIn(extDataIn),
    .extNcs(extNcs), .extAddr(extAddr), .extNlbA0(extNlbA0), .extNub(extNub),
    .extDataOut(extDataOut), .extDataOe(extDataOe),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int NUM_CS = 8,
  parameter int EXT_AW = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              extMck,
  input logic [NUM_CS-1:0] extNcs,
  input logic [EXT_AW-1:0] extAddr,
  input logic              extNrd,
  input logic              extNwr,
  input logic              extDataOe
);
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~extNcs));
  p_strobe_cs_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!extNrd || !extNwr) |-> (extNcs != '1));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (extNcs != '1 && extNcs == $past(extNcs)) |-> $stable(extAddr));
  p_wr_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extNwr) |-> $rose(extMck));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    extNrd || extNwr);
  p_wr_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!extNwr || $rose(extNwr)) |-> extDataOe);
  p_rsp_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $rose(extNrd));
  p_rsp_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  p_rd_nodrive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !extNrd |-> !extDataOe);
  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (extMck && extNrd && extNwr && extNcs == '1));
endmodule

bind ebc_top ebc_checker #(.NUM_CS(NUM_CS), .EXT_AW(EXT_AW)) u_chk (.*);

// File: tb/sim_ebc_top.sv
module sim_ebc_top;
  localparam int NCS = 8;
  localparam int AW  = 26;
  localparam int EAW = 23;
  localparam int DW  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic [NCS*8-1:0] cfgTable;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0]    reqBe = 2'b11;
  logic          reqReady, rspValid, extMck, extNlbA0, extNub, extNrd, extNwr, extDataOe;
  logic [DW-1:0] rspRdata, extDataOut, extDataIn;
  logic [NCS-1:0] extNcs;
  logic [EAW-1:0] extAddr;
  logic          extNwait = 1'b1;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  ebc_top u0 (.*);

  // per select: {flt[7:5], early[4], waits[3:1], wide[0]}
  initial cfgTable = {8'h28, 8'h0F, 8'h13, 8'h70, 8'h02, 8'h57, 8'h25, 8'h01};

  function automatic logic [15:0] devWord(input logic [EAW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction
  assign extDataIn = devWord(extAddr);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct {
    bit isRd; bit isWr0; string wTag;
    logic [NCS-1:0] exCs; logic [EAW-1:0] exAddr; bit exNlb; bit exNub;
    int base; bit startMck; bit endMck; int csLead;
    logic [15:0] exData; int exGap; bit expStall;
  } expT;
  expT q[$];

  int stallLeft = 0;
  always @(posedge clk) begin
    #2;
    if (stallLeft > 0 && (!extNrd || !extNwr)) begin
      extNwait = 1'b0;
      stallLeft--;
    end else extNwait = 1'b1;
  end

  // scoreboard driver
  task automatic access(input bit wr, input int sel, input logic [EAW-1:0] off,
                        input logic [15:0] wd, input logic [1:0] be,
                        input int gap, input int stall);
    expT e;
    logic [7:0] c;
    int n;
    bit wide, early;
    logic [7:0] b;
    logic [15:0] dev;
    c = cfgTable[sel*8 +: 8];
    wide = c[0]; n = int'(c[3:1]); early = c[4];
    e.isRd = !wr; e.isWr0 = wr && n == 0;
    e.exCs = ~(NCS'(1) << sel);
    e.exAddr = off;
    e.exNlb = ~be[0];
    e.exNub = wide ? ~be[1] : 1'b1;
    if (wr) begin
      e.base = (n == 0) ? 1 : 2 * n;
      e.wTag = (n == 0) ? "R3" : "R4";
      e.startMck = 1'b1; e.endMck = (n != 0); e.csLead = 1;
      b = be[0] ? wd[7:0] : wd[15:8];
      e.exData = wide ? wd : {b, b};
    end else begin
      e.base = early ? 2 * n + 2 : 2 * n + 1;
      e.wTag = early ? "R6" : "R5";
      e.startMck = !early; e.endMck = 1'b0; e.csLead = early ? 0 : 1;
      dev = devWord(off);
      e.exData = wide ? dev : {dev[7:0], dev[7:0]};
    end
    e.exGap = gap;
    e.expStall = (stall > 0) && !e.isWr0;
    if (stall > 0) e.wTag = "R7";
    q.push_back(e);
    stallLeft = stall;
    reqValid = 1'b1; reqWrite = wr;
    reqAddr = {sel[2:0], off}; reqWdata = wd; reqBe = be;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
  endtask

  // monitor
  int smp = 0, csRiseS = -1000, csFallS = 0, lowCnt = 0, extra = 0;
  bit pNrd = 1'b1, pNwr = 1'b1, pCsIdle = 1'b1, active = 1'b0;
  expT cur;
  always @(negedge clk) begin
    if (rstN) begin
      bit csIdle, lowNow;
      smp++;
      csIdle = (extNcs == '1);
      lowNow = !extNrd || !extNwr;
      if (pCsIdle && !csIdle) csFallS = smp;
      if (!pCsIdle && csIdle) csRiseS = smp;
      if ((pNrd && !extNrd) || (pNwr && !extNwr)) begin
        if (q.size() == 0) chk(1'b0, "R1 unexpected strobe", 1, 0);
        else begin
          cur = q.pop_front();
          active = 1'b1; lowCnt = 0; extra = 0;
          chk(extNcs == cur.exCs, "R1 select", extNcs, cur.exCs);
          chk(extAddr == cur.exAddr, "R2 address", extAddr, cur.exAddr);
          chk(extNlbA0 == cur.exNlb && extNub == cur.exNub, "R2 byte strobes",
              {extNub, extNlbA0}, {cur.exNub, cur.exNlb});
          chk(extMck == cur.startMck, {cur.wTag, " strobe start phase"}, extMck, cur.startMck);
          chk(smp - csFallS == cur.csLead, {cur.wTag, " select to strobe"}, smp - csFallS, cur.csLead);
          chk(!extNrd == cur.isRd, "R8 strobe kind", extNrd, !cur.isRd);
          chk(!reqReady, "R11 busy", reqReady, 0);
          if (cur.exGap >= 0)
            chk(csFallS - csRiseS == cur.exGap, "R10 float gap", csFallS - csRiseS, cur.exGap);
        end
      end
      if (active && lowNow) begin
        lowCnt++;
        if (!extMck && !extNwait) extra++;
      end else if (active) begin
        active = 1'b0;
        chk(lowCnt == cur.base + 2 * extra, {cur.wTag, " strobe width"}, lowCnt, cur.base + 2 * extra);
        if (cur.expStall) chk(extra > 0, "R7 wait taken", extra, 1);
        if (cur.isWr0) chk(extra == 0, "R7 zero-wait write", extra, 0);
        chk(extMck == cur.endMck, {cur.wTag, " strobe end phase"}, extMck, cur.endMck);
        chk(extNcs == cur.exCs && extAddr == cur.exAddr, "R8 select held", extNcs, cur.exCs);
        if (cur.isRd) begin
          chk(rspValid == 1'b1, "R9 response valid", rspValid, 1);
          chk(rspRdata == cur.exData, "R9 read data", rspRdata, cur.exData);
        end else begin
          chk(rspValid == 1'b0, "R9 no write response", rspValid, 0);
          chk(extDataOe && extDataOut == cur.exData, "R8 write data held",
              {extDataOe, extDataOut}, {1'b1, cur.exData});
        end
      end
      pNrd = extNrd; pNwr = extNwr; pCsIdle = csIdle;
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    bit r1, m1, r2, m2;
    repeat (4) @(negedge clk);
    chk(extNcs == '1, "R1 reset selects", extNcs, '1);
    chk(extNrd && extNwr && !extDataOe && !rspValid, "R11 reset strobes",
        {extNrd, extNwr, extDataOe, rspValid}, 4'b1100);
    chk(!reqReady, "R11 reset ready", reqReady, 0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    r1 = reqReady; m1 = extMck;
    @(negedge clk);
    r2 = reqReady; m2 = extMck;
    chk(r1 == m1 && r2 == m2 && r1 != r2, "R11 ready follows bus clock", {r1, r2}, {m1, m2});

    access(1, 0, 23'h000123, 16'hBEEF, 2'b11, -1, 0);       // R3
    access(1, 1, 23'h012345, 16'h1234, 2'b10, -1, 0);       // R4, upper byte only
    access(0, 1, 23'h00ABCD, 16'h0000, 2'b11, -1, 0);       // R5
    access(0, 2, 23'h7FFFFF, 16'h0000, 2'b11, -1, 0);       // R6, float 2
    access(0, 0, 23'h000010, 16'h0000, 2'b11, 5, 0);        // R10 gap 2*2+1
    access(1, 5, 23'h002222, 16'h55AA, 2'b01, 3, 0);        // R10 gap 2*1+1
    access(0, 3, 23'h003456, 16'h0000, 2'b10, -1, 0);       // R2 8-bit read, A0=1
    access(0, 4, 23'h004567, 16'h0000, 2'b01, -1, 0);       // 8-bit early, float 3+1
    access(0, 6, 23'h005678, 16'h0000, 2'b11, 9, 0);        // R10 gap 2*4+1
    access(1, 7, 23'h006789, 16'hA55A, 2'b10, -1, 0);       // R2 8-bit write byte
    waitIdle();
    access(0, 6, 23'h001111, 16'h0000, 2'b11, -1, 5);       // R7 read stall
    waitIdle();
    access(1, 1, 23'h002468, 16'hCAFE, 2'b11, -1, 3);       // R7 stall on releasing edge
    waitIdle();
    access(1, 0, 23'h000999, 16'h0F0F, 2'b11, -1, 4);       // R7 zero-wait write
    waitIdle();
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9 all accesses seen", q.size(), 0);
    summary();
  end
endmodule